// File: doc/BRIEF.md
# Banked Dual-Read Register File

This block is the context store of a microprogrammed processor: 2048 words of 32 bits, held as two identical copies. Each copy drives one read bus, X or Y, so both ALU operands can come from different words in the same cycle. The single write port updates both copies at the same address, which keeps them identical at all times. Writes take effect on the clock edge. Reads are combinational.

The low 64 words are general registers. Above them sit 31 banks of 16 capability registers: seven banks for the kernel, then 24 for user processes. Each capability takes four consecutive words, one for each part, so one bank spans 64 words. Each port has its own 2-bit mode, which turns a microcode field, the current instruction's fields or an 11-bit bank-select register into a word address. In mode 3 the full bank-select value acts as a pointer, so a save or restore loop can step through the whole file.

Top module: `dualread_bank_regfile`

## Requirements
- R1: After reset the bank-select register, visible on `bank_sel`, reads 0.
- R2: A write lands in both copies: X and Y reading the same word return the same value, equal to the last data written there.
- R3: Mode 0 addresses the general-register word given by the port's 6-bit direct field (word 0..63).
- R4: Mode 1 addresses word INDEX_BASE (default 4) plus the instruction's 2-bit index field.
- R5: Mode 2 addresses word 64 + 64×bank + 4×cap + part. Here bank is bits [4:0] of the bank-select register, cap is the instruction's 4-bit capability field, and part is 0 for base, 1 for limit, 2 for offset and 3 for rights.
- R6: Mode 3 addresses the word given by all 11 bits of the bank-select register.
- R7: The X and Y ports resolve their modes and fields independently and can read different words in the same cycle.
- R8: A read of the word being written in the same cycle returns the old data. The new data is visible from the next cycle on.
- R9: `bank_load` high stores `bank_value` into the bank-select register at the clock edge. With `bank_load` low the register holds. An address formed in the cycle of a load uses the old value.
- R10: With `w_en` low no word changes, whatever the other write inputs carry.
- R11: The write address is formed by the same four modes from the write port's own mode, direct and part fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the bank-select register |
| bank_load | input | 1 | Load strobe for the bank-select register |
| bank_value | input | 11 | Value to load into the bank-select register |
| bank_sel | output | 11 | Current bank-select register |
| ir_cap | input | 4 | Capability-register field of the current instruction |
| ir_idx | input | 2 | Index-register field of the current instruction |
| x_mode | input | 2 | X port addressing mode (0 direct, 1 index, 2 capability, 3 bank pointer) |
| x_direct | input | 6 | X port direct general-register number |
| x_part | input | 2 | X port capability part selector |
| x_data | output | 32 | X read data |
| y_mode | input | 2 | Y port addressing mode |
| y_direct | input | 6 | Y port direct general-register number |
| y_part | input | 2 | Y port capability part selector |
| y_data | output | 32 | Y read data |
| w_en | input | 1 | Write enable |
| w_mode | input | 2 | Write port addressing mode |
| w_direct | input | 6 | Write port direct general-register number |
| w_part | input | 2 | Write port capability part selector |
| w_data | input | 32 | Write data |

## Verification
The capability-mode properties assume that bank field bits [4:0] are at most 30 whenever a port selects mode 2. Field value 31 would run past word 2047 and wrap into the general registers. The stimulus tracks the bank-select value it has loaded, and when a port would pick mode 2 with that field at 31 it switches the port to mode 3. The mirroring and write-landing properties assume no input changes between clock edges. The bench drives all inputs once per cycle, just after the falling edge.

// File: rtl/drrf_pkg.sv
// Shared types of the banked dual-read register file.
// Assumes: mode and part codes are fixed by the microcode format.
package drrf_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'd0,   // word number straight from microcode
        AM_INDEX  = 2'd1,   // index register named by the instruction
        AM_CAP    = 2'd2,   // capability part in the selected bank
        AM_BANKPTR = 2'd3   // bank-select register used as a pointer
    } addr_mode_t;

    typedef enum logic [1:0] {
        PART_BASE   = 2'd0,
        PART_LIMIT  = 2'd1,
        PART_OFFSET = 2'd2,
        PART_RIGHTS = 2'd3
    } cap_part_t;

endpackage

// File: rtl/drrf_addr_former.sv
// Address former: turns one port's mode and fields into a word address.
// Assumes: the capability region starts right after the general registers
// and each capability takes 2**PART_W consecutive words.
module drrf_addr_former
    import drrf_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DIR_W      = 6,
    parameter int CAP_W      = 4,
    parameter int IDX_W      = 2,
    parameter int PART_W     = 2,
    parameter int BANKF_W    = 5,
    parameter int GEN_WORDS  = 64,
    parameter int INDEX_BASE = 4
) (
    input  logic [1:0]        mode,
    input  logic [DIR_W-1:0]  direct,
    input  logic [CAP_W-1:0]  cap,
    input  logic [IDX_W-1:0]  idx,
    input  logic [PART_W-1:0] part,
    input  logic [ADDR_W-1:0] bank_sel,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] GEN_BASE = ADDR_W'(GEN_WORDS);
    localparam logic [ADDR_W-1:0] IDX_BASE = ADDR_W'(INDEX_BASE);

    logic [BANKF_W+CAP_W+PART_W-1:0] cap_offset;

    // Capability word offset inside the capability region.
    always_comb cap_offset = {bank_sel[BANKF_W-1:0], cap, part};

    // Select the address source for the requested mode.
    always_comb begin
        unique case (addr_mode_t'(mode))
            AM_DIRECT: addr = ADDR_W'(direct);
            AM_INDEX:  addr = IDX_BASE + ADDR_W'(idx);
            AM_CAP:    addr = GEN_BASE + ADDR_W'(cap_offset);
            default:   addr = bank_sel;
        endcase
    end

endmodule

// File: rtl/drrf_mirror_store.sv
// Mirrored storage: COPIES identical arrays, one write port shared by all,
// one combinational read port per copy.
// Assumes: contents are not reset; software writes a word before reading it.
module drrf_mirror_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2048,
    parameter int COPIES = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              w_en,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [WORD_W-1:0] w_data,
    input  logic [ADDR_W-1:0] rd_addr [COPIES],
    output logic [WORD_W-1:0] rd_data [COPIES]
);

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        logic [WORD_W-1:0] mem [DEPTH];

        // Mirror every write into this copy.
        always_ff @(posedge clk) begin
            if (w_en) mem[w_addr] <= w_data;
        end

        // Asynchronous read; shows pre-edge contents during a write.
        assign rd_data[c] = mem[rd_addr[c]];
    end

endmodule

// File: rtl/drrf_bank_reg.sv
// Bank-select register: chooses the capability bank and serves as a
// pointer for whole-file save and restore.
// Assumes: synchronous active-low reset to bank 0.
module drrf_bank_reg #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] q
);

    // Load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= value;
    end

endmodule

// File: rtl/dualread_bank_regfile.sv
// Banked dual-read register file: two mirrored copies of the context
// store, three address formers (X, Y, write) and the bank-select register.
// Assumes: inputs are stable between clock edges; in capability mode the
// bank field of the bank-select register stays below BANK_COUNT.
module dualread_bank_regfile #(
    parameter int WORD_W        = 32,
    parameter int GEN_WORDS     = 64,
    parameter int CAPS_PER_BANK = 16,
    parameter int CAP_PARTS     = 4,
    parameter int BANK_COUNT    = 31,
    parameter int INDEX_REGS    = 4,
    parameter int INDEX_BASE    = 4,
    localparam int BANK_WORDS = CAPS_PER_BANK * CAP_PARTS,
    localparam int DEPTH      = GEN_WORDS + BANK_COUNT * BANK_WORDS,
    localparam int ADDR_W     = $clog2(DEPTH),
    localparam int DIR_W      = $clog2(GEN_WORDS),
    localparam int CAP_W      = $clog2(CAPS_PER_BANK),
    localparam int PART_W     = $clog2(CAP_PARTS),
    localparam int IDX_W      = $clog2(INDEX_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_load,
    input  logic [ADDR_W-1:0] bank_value,
    output logic [ADDR_W-1:0] bank_sel,
    input  logic [CAP_W-1:0]  ir_cap,
    input  logic [IDX_W-1:0]  ir_idx,
    input  logic [1:0]        x_mode,
    input  logic [DIR_W-1:0]  x_direct,
    input  logic [PART_W-1:0] x_part,
    output logic [WORD_W-1:0] x_data,
    input  logic [1:0]        y_mode,
    input  logic [DIR_W-1:0]  y_direct,
    input  logic [PART_W-1:0] y_part,
    output logic [WORD_W-1:0] y_data,
    input  logic              w_en,
    input  logic [1:0]        w_mode,
    input  logic [DIR_W-1:0]  w_direct,
    input  logic [PART_W-1:0] w_part,
    input  logic [WORD_W-1:0] w_data
);

    localparam int BANKF_W = $clog2(BANK_COUNT);
    localparam int PORTS   = 3;   // 0: X, 1: Y, 2: write
    localparam int COPIES  = 2;

    logic [1:0]        mode_a   [PORTS];
    logic [DIR_W-1:0]  direct_a [PORTS];
    logic [PART_W-1:0] part_a   [PORTS];
    logic [ADDR_W-1:0] addr_a   [PORTS];
    logic [ADDR_W-1:0] rd_addr  [COPIES];
    logic [WORD_W-1:0] rd_data  [COPIES];
    logic [ADDR_W-1:0] x_addr, y_addr, w_addr;

    // Gather per-port addressing fields.
    always_comb begin
        mode_a[0] = x_mode; direct_a[0] = x_direct; part_a[0] = x_part;
        mode_a[1] = y_mode; direct_a[1] = y_direct; part_a[1] = y_part;
        mode_a[2] = w_mode; direct_a[2] = w_direct; part_a[2] = w_part;
    end

    drrf_bank_reg #(.ADDR_W(ADDR_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bank_load),
        .value (bank_value),
        .q     (bank_sel)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        drrf_addr_former #(
            .ADDR_W     (ADDR_W),
            .DIR_W      (DIR_W),
            .CAP_W      (CAP_W),
            .IDX_W      (IDX_W),
            .PART_W     (PART_W),
            .BANKF_W    (BANKF_W),
            .GEN_WORDS  (GEN_WORDS),
            .INDEX_BASE (INDEX_BASE)
        ) u_form (
            .mode     (mode_a[p]),
            .direct   (direct_a[p]),
            .cap      (ir_cap),
            .idx      (ir_idx),
            .part     (part_a[p]),
            .bank_sel (bank_sel),
            .addr     (addr_a[p])
        );
    end

    // Name the formed addresses per port.
    always_comb begin
        x_addr     = addr_a[0];
        y_addr     = addr_a[1];
        w_addr     = addr_a[2];
        rd_addr[0] = x_addr;
        rd_addr[1] = y_addr;
    end

    drrf_mirror_store #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .COPIES (COPIES)
    ) u_store (
        .clk     (clk),
        .w_en    (w_en),
        .w_addr  (w_addr),
        .w_data  (w_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Copy 0 feeds the X bus, copy 1 the Y bus.
    always_comb begin
        x_data = rd_data[0];
        y_data = rd_data[1];
    end

endmodule

// File: rtl/dualread_bank_regfile_checker.sv
// Checker for the banked dual-read register file, bound to the top module.
// Assumes: the capability bank field stays below the bank count in mode 2.
module dualread_bank_regfile_checker #(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 11,
    parameter int GEN_WORDS = 64,
    parameter int BANKF_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_load,
    input logic [ADDR_W-1:0] bank_value,
    input logic [ADDR_W-1:0] bank_sel,
    input logic [1:0]        x_mode,
    input logic [ADDR_W-1:0] x_addr,
    input logic [ADDR_W-1:0] y_addr,
    input logic [ADDR_W-1:0] w_addr,
    input logic              w_en,
    input logic [WORD_W-1:0] w_data,
    input logic [WORD_W-1:0] x_data,
    input logic [WORD_W-1:0] y_data
);

    localparam logic [BANKF_W-1:0] LAST_FIELD = '1;

    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_load |=> $stable(bank_sel));

    assert_bank_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load |=> bank_sel == $past(bank_value));

    assert_copies_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_addr == y_addr) |-> (x_data == y_data));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        w_en |=> ((x_addr != $past(w_addr)) || (x_data == $past(w_data))));

    assert_direct_in_general_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mode == 2'd0) |-> (x_addr < ADDR_W'(GEN_WORDS)));

    assert_cap_above_general_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mode == 2'd2 && bank_sel[BANKF_W-1:0] != LAST_FIELD)
            |-> (x_addr >= ADDR_W'(GEN_WORDS)));

endmodule

bind dualread_bank_regfile dualread_bank_regfile_checker #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .GEN_WORDS (GEN_WORDS),
    .BANKF_W   (BANKF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_load  (bank_load),
    .bank_value (bank_value),
    .bank_sel   (bank_sel),
    .x_mode     (x_mode),
    .x_addr     (x_addr),
    .y_addr     (y_addr),
    .w_addr     (w_addr),
    .w_en       (w_en),
    .w_data     (w_data),
    .x_data     (x_data),
    .y_data     (y_data)
);

// File: tb/dualread_bank_regfile_bench.sv
// Bench: behavioural reference model of the file, compared every cycle.
module dualread_bank_regfile_bench;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 2048;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bank_load;
    logic [10:0] bank_value, bank_sel;
    logic [3:0]  ir_cap;
    logic [1:0]  ir_idx;
    logic [1:0]  x_mode, y_mode, w_mode;
    logic [5:0]  x_direct, y_direct, w_direct;
    logic [1:0]  x_part, y_part, w_part;
    logic [31:0] x_data, y_data, w_data;
    logic        w_en;

    int unsigned model_mem [DEPTH];
    int          model_bank;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          cmp_data = 1'b0;
    bit          finished = 1'b0;
    string       tag_over = "";

    dualread_bank_regfile u_dualread_bank_regfile (
        .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_value(bank_value),
        .bank_sel(bank_sel), .ir_cap(ir_cap), .ir_idx(ir_idx),
        .x_mode(x_mode), .x_direct(x_direct), .x_part(x_part), .x_data(x_data),
        .y_mode(y_mode), .y_direct(y_direct), .y_part(y_part), .y_data(y_data),
        .w_en(w_en), .w_mode(w_mode), .w_direct(w_direct), .w_part(w_part),
        .w_data(w_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Word address from the requirements R3..R6.
    function automatic int calc_addr(int mode, int dir, int part);
        case (mode)
            0:       return dir;
            1:       return 4 + int'(ir_idx);
            2:       return (64 + (model_bank % 32) * 64 + int'(ir_cap) * 4 + part) % DEPTH;
            default: return model_bank;
        endcase
    endfunction

    function automatic string mode_tag(int mode);
        if (tag_over != "") return tag_over;
        case (mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One cycle: compare before the edge, then advance the model.
    task automatic cycle();
        int wa;
        #(PERIOD/4);
        check("R9 bank_sel", {21'd0, bank_sel}, model_bank);
        if (cmp_data) begin
            check({mode_tag(x_mode), " X"}, x_data,
                  model_mem[calc_addr(x_mode, x_direct, x_part)]);
            check({mode_tag(y_mode), " Y"}, y_data,
                  model_mem[calc_addr(y_mode, y_direct, y_part)]);
        end
        wa = calc_addr(w_mode, w_direct, w_part);
        @(posedge clk);
        #1;
        if (w_en) model_mem[wa] = w_data;
        if (bank_load) model_bank = int'(bank_value);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        bank_load = 0; bank_value = 0; ir_cap = 0; ir_idx = 0;
        x_mode = 0; x_direct = 0; x_part = 0;
        y_mode = 0; y_direct = 0; y_part = 0;
        w_en = 0; w_mode = 0; w_direct = 0; w_part = 0; w_data = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        model_bank = 0;
        repeat (3) @(negedge clk);
        #1; rst_n = 1;
        @(negedge clk);
        // R1: bank-select register cleared by reset
        check("R1 reset bank_sel", {21'd0, bank_sel}, 32'd0);

        // Fill every word through the bank pointer (R6, R11), loading the
        // next pointer in the same cycle (old value used, R9).
        for (int a = 0; a < DEPTH; a++) begin
            bank_load = 1; bank_value = 11'((a + 1) % DEPTH);
            w_en = 1; w_mode = 3; w_data = $urandom;
            cycle();
        end
        idle_inputs();
        cmp_data = 1;
        cycle();

        // R2: same word on both ports after a direct write
        w_en = 1; w_mode = 0; w_direct = 10; w_data = 32'hA5A5_0010;
        cycle();
        w_en = 0; tag_over = "R2";
        x_mode = 0; x_direct = 10; y_mode = 0; y_direct = 10;
        cycle();
        check("R2 direct", x_data, 32'hA5A5_0010);
        // R7: different words on X and Y in one cycle
        tag_over = "R7"; y_direct = 11;
        cycle();

        // R8: read during write returns old, new next cycle
        tag_over = "R8";
        x_direct = 20; w_en = 1; w_mode = 0; w_direct = 20; w_data = 32'h1234_5678;
        cycle();
        w_en = 0;
        cycle();
        check("R8 after", x_data, 32'h1234_5678);

        // R10: disabled write leaves the word alone
        tag_over = "R10";
        w_en = 0; w_direct = 20; w_data = 32'hDEAD_BEEF;
        cycle();
        cycle();

        // R4: index mode for each index field value
        tag_over = "R4";
        for (int i = 0; i < 4; i++) begin
            x_mode = 1; ir_idx = 2'(i); y_mode = 0; y_direct = 6'(4 + i);
            cycle();
        end

        // R11 + R5: write a capability part, read it back by mode 2
        tag_over = "R11";
        bank_load = 1; bank_value = 11'd30;
        cycle();
        bank_load = 0;
        ir_cap = 4'd15; w_en = 1; w_mode = 2; w_part = 3; w_data = 32'hCAFE_0003;
        cycle();
        w_en = 0; tag_over = "R5";
        x_mode = 2; x_part = 3; y_mode = 2; y_part = 0;
        cycle();
        check("R5 last word", x_data, 32'hCAFE_0003);

        // Random mix of all modes and fields.
        tag_over = "";
        for (int n = 0; n < 6000; n++) begin
            bank_load = ($urandom % 4) == 0;
            bank_value = 11'($urandom);
            ir_cap = 4'($urandom); ir_idx = 2'($urandom);
            x_mode = 2'($urandom); x_direct = 6'($urandom); x_part = 2'($urandom);
            y_mode = 2'($urandom); y_direct = 6'($urandom); y_part = 2'($urandom);
            w_en = 1'($urandom); w_mode = 2'($urandom);
            w_direct = 6'($urandom); w_part = 2'($urandom); w_data = $urandom;
            if ((model_bank % 32) == 31) begin
                if (x_mode == 2) x_mode = 3;
                if (y_mode == 2) y_mode = 3;
                if (w_mode == 2) w_mode = 3;
            end
            cycle();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule